// File: doc/BRIEF.md
# Calendar Clock with Two-Button Adjustment

This block keeps a calendar time of day (seconds, minutes, hours, date, month) together with a four-step leap-year phase. A one-second strobe advances the time. A millisecond strobe drives the button debouncers, the hold and repeat timers, the inactivity timeout and the blink phase. The time is presented as packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. The hour is shown in either 24-hour or 12-hour form.

Two active-high push buttons set the clock while clock mode is selected. The first button walks a cursor over the editable fields. The second button bumps the field under the cursor, and it auto-repeats while held. The block reports which field is under the cursor, plus a blink mask that the display uses to flash that field.

Two resets exist. A power-on reset initialises everything, including the time. A control reset clears only the adjustment machinery and leaves the time untouched.

Top module: `calendar_setter`

## Requirements
- R1: After power-on reset the outputs read month 01, date 01, 00:00:00, leap phase 0, with field_sel and blink all zero.
- R2: Each sec_tick advances the time with carries: seconds and minutes run 0..59 and hours run 0..23. The date wraps after the month length: 30 days for months 4, 6, 9 and 11, and 31 days for the other months except February. February has 29 days when the leap phase is 0 and 28 days otherwise. The month wraps 12 to 1.
- R3: The leap phase counts 0..3 and wraps. It advances only when the date rolls over from 31 December to 1 January.
- R4: With hour12 high, hour 0 reads 12, hours 13..23 read 1..11, and hours 1..12 read unchanged. With hour12 low, hour_bcd shows 0..23.
- R5: While clock_mode is high, each debounced MODE press steps the cursor through run, month, date, hour, minute, leap and back to run. Seconds are never selected. field_sel is one-hot: bit0 month, bit1 date, bit2 hour, bit3 minute, bit4 leap. When clock_mode is low, MODE presses are ignored and the block is forced to run.
- R6: Each debounced SET press while editing adds one to the selected field. The field wraps within its own range: month 1..12, date 1..month length, hour 0..23, minute 0..59, leap 0..3.
- R7: Every SET increment clears seconds to 0. After any SET press in an edit session, sec_tick is ignored until the block returns to run. Without a SET press the time keeps running during editing.
- R8: SET held for HOLD_MS millisecond ticks starts auto-repeat. After that, one further increment occurs every REPEAT_MS ticks for as long as SET stays down.
- R9: If IDLE_MS millisecond ticks pass with no MODE press while editing, the block returns to run.
- R10: A button changes its debounced state only after its raw level has differed from that state for DEBOUNCE_MS consecutive millisecond ticks. A shorter pulse has no effect.
- R11: While editing, blink equals field_sel during the first half of each MS_PER_SEC-tick period and is zero in the second half. Outside editing, blink is zero.
- R12: Control reset returns the block to run and leaves every time field and the leap phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| ctl_rst_n | input | 1 | Control reset, active low, synchronous; time preserved |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| sec_tick | input | 1 | One-cycle one-second strobe |
| clock_mode | input | 1 | High when clock display/adjust is selected |
| hour12 | input | 1 | High selects 12-hour display |
| btn_mode | input | 1 | Raw field-select button, active high |
| btn_set | input | 1 | Raw increment button, active high |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours, BCD, format per hour12 |
| date_bcd | output | 8 | Day of month, BCD |
| month_bcd | output | 8 | Month, BCD |
| leap_phase | output | 2 | Leap-year phase 0..3 |
| field_sel | output | 5 | One-hot field under edit |
| blink | output | 5 | field_sel gated by the 1 Hz blink phase |

## Verification
The assertions assume that sec_tick and ms_tick are single-cycle strobes. They also assume that the buttons only change in ways the debouncer can filter, and that power-on reset is applied before anything else happens. Under those conditions, only a second rollover or a SET increment can move the minutes, and the leap phase can only move while running if it lands on 1 January. The stimulus drives all inputs on falling clock edges and holds ms_tick high so every cycle is a millisecond. It issues sec_tick only as isolated one-cycle pulses. It holds buttons for exactly known counts of cycles, and in the hold tests it places the release midway between auto-repeat instants, so each expected increment count is unambiguous.

// File: rtl/calendar_setter.sv
module calendar_setter #(
  parameter int MS_PER_SEC  = 1000,
  parameter int DEBOUNCE_MS = 35,
  parameter int HOLD_MS     = 2000,
  parameter int REPEAT_MS   = 125,
  parameter int IDLE_MS     = 15000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ctl_rst_n,
  input  logic       ms_tick,
  input  logic       sec_tick,
  input  logic       clock_mode,
  input  logic       hour12,
  input  logic       btn_mode,
  input  logic       btn_set,
  output logic [7:0] sec_bcd,
  output logic [7:0] min_bcd,
  output logic [7:0] hour_bcd,
  output logic [7:0] date_bcd,
  output logic [7:0] month_bcd,
  output logic [1:0] leap_phase,
  output logic [4:0] field_sel,
  output logic [4:0] blink
);
  localparam int DW = $clog2(DEBOUNCE_MS + 1);
  localparam int HW = $clog2(HOLD_MS + 1);
  localparam int RW = $clog2(REPEAT_MS + 1);
  localparam int IW = $clog2(IDLE_MS + 1);
  localparam int BW = $clog2(MS_PER_SEC + 1);

  logic          ctl_clr;
  logic [1:0]    raw, st, rise;
  logic [DW-1:0] dcnt [2];
  logic [HW-1:0] hold_cnt;
  logic [RW-1:0] rep_cnt;
  logic [IW-1:0] idle;
  logic [BW-1:0] bcnt;
  logic [2:0]    sel, sel_nxt;
  logic          dirty, adj, timeout, rep_ev, inc, run;
  logic [5:0]    sec, mins;
  logic [4:0]    hour, date, mlen, h12;
  logic [3:0]    mon;
  logic [1:0]    leap;

  function automatic logic [7:0] to_bcd(input logic [5:0] v);
    return {4'(v / 6'd10), 4'(v % 6'd10)};
  endfunction

  assign ctl_clr = !por_n || !ctl_rst_n;
  assign raw     = {btn_set, btn_mode};

  for (genvar i = 0; i < 2; i++) begin : g_rise
    assign rise[i] = ms_tick && raw[i] && !st[i] && (dcnt[i] == DW'(DEBOUNCE_MS - 1));
  end

  always_ff @(posedge clk) begin
    if (ctl_clr) begin
      st <= '0;
      for (int i = 0; i < 2; i++) dcnt[i] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (raw[i] == st[i]) dcnt[i] <= '0;
        else if (ms_tick) begin
          if (dcnt[i] == DW'(DEBOUNCE_MS - 1)) begin
            st[i]   <= raw[i];
            dcnt[i] <= '0;
          end else dcnt[i] <= dcnt[i] + 1'b1;
        end
      end
    end
  end

  assign adj     = (sel != 3'd0);
  assign timeout = adj && ms_tick && (idle == IW'(IDLE_MS - 1));
  assign rep_ev  = adj && st[1] && ms_tick && (hold_cnt == HW'(HOLD_MS)) &&
                   (rep_cnt == RW'(REPEAT_MS - 1));
  assign inc     = adj && (rise[1] || rep_ev);
  assign run     = sec_tick && !(adj && dirty);

  always_comb begin
    sel_nxt = sel;
    if (!clock_mode) sel_nxt = '0;
    else if (rise[0]) sel_nxt = (sel == 3'd5) ? 3'd0 : sel + 3'd1;
    else if (timeout) sel_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (ctl_clr) begin
      sel      <= '0;
      dirty    <= 1'b0;
      idle     <= '0;
      hold_cnt <= '0;
      rep_cnt  <= '0;
      bcnt     <= '0;
    end else begin
      sel   <= sel_nxt;
      dirty <= (sel_nxt != 3'd0) && (dirty || inc);
      if (!adj || rise[0]) idle <= '0;
      else if (ms_tick) idle <= idle + 1'b1;
      if (!adj || !st[1]) begin
        hold_cnt <= '0;
        rep_cnt  <= '0;
      end else if (ms_tick) begin
        if (hold_cnt != HW'(HOLD_MS)) hold_cnt <= hold_cnt + 1'b1;
        else if (rep_cnt == RW'(REPEAT_MS - 1)) rep_cnt <= '0;
        else rep_cnt <= rep_cnt + 1'b1;
      end
      if (ms_tick) bcnt <= (bcnt == BW'(MS_PER_SEC - 1)) ? '0 : bcnt + 1'b1;
    end
  end

  always_comb begin
    case (mon)
      4'd2:                      mlen = (leap == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   mlen = 5'd30;
      default:                   mlen = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      sec  <= '0;
      mins <= '0;
      hour <= '0;
      date <= 5'd1;
      mon  <= 4'd1;
      leap <= '0;
    end else if (inc) begin
      sec <= '0;
      case (sel)
        3'd1: mon  <= (mon == 4'd12) ? 4'd1 : mon + 4'd1;
        3'd2: date <= (date >= mlen) ? 5'd1 : date + 5'd1;
        3'd3: hour <= (hour == 5'd23) ? 5'd0 : hour + 5'd1;
        3'd4: mins <= (mins == 6'd59) ? 6'd0 : mins + 6'd1;
        3'd5: leap <= leap + 2'd1;
        default: ;
      endcase
    end else if (run) begin
      sec <= (sec == 6'd59) ? 6'd0 : sec + 6'd1;
      if (sec == 6'd59) begin
        mins <= (mins == 6'd59) ? 6'd0 : mins + 6'd1;
        if (mins == 6'd59) begin
          hour <= (hour == 5'd23) ? 5'd0 : hour + 5'd1;
          if (hour == 5'd23) begin
            date <= (date >= mlen) ? 5'd1 : date + 5'd1;
            if (date >= mlen) begin
              mon <= (mon == 4'd12) ? 4'd1 : mon + 4'd1;
              if (mon == 4'd12) leap <= leap + 2'd1;
            end
          end
        end
      end
    end
  end

  assign h12        = (hour == 5'd0) ? 5'd12 : (hour > 5'd12) ? hour - 5'd12 : hour;
  assign sec_bcd    = to_bcd(sec);
  assign min_bcd    = to_bcd(mins);
  assign hour_bcd   = to_bcd({1'b0, hour12 ? h12 : hour});
  assign date_bcd   = to_bcd({1'b0, date});
  assign month_bcd  = to_bcd({2'b0, mon});
  assign leap_phase = leap;
  assign field_sel  = adj ? 5'(5'd1 << (sel - 3'd1)) : 5'd0;
  assign blink      = field_sel & {5{bcnt < BW'(MS_PER_SEC / 2)}};
endmodule

// File: rtl/calendar_setter_sva.sv
module calendar_setter_sva (
  input logic       clk,
  input logic       por_n,
  input logic       clock_mode,
  input logic [7:0] sec_bcd,
  input logic [7:0] min_bcd,
  input logic [7:0] date_bcd,
  input logic [7:0] month_bcd,
  input logic [1:0] leap_phase,
  input logic [4:0] field_sel,
  input logic [4:0] blink
);
  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(field_sel));

  assert_mode_gate_R5: assert property (@(posedge clk) disable iff (!por_n)
    !clock_mode |=> field_sel == 5'd0);

  assert_blink_within_R11: assert property (@(posedge clk) disable iff (!por_n)
    (blink & ~field_sel) == 5'd0);

  assert_sec_legal_R2: assert property (@(posedge clk) disable iff (!por_n)
    sec_bcd[7:4] <= 4'd5 && sec_bcd[3:0] <= 4'd9);

  assert_min_zero_sec_R7: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(min_bcd) |-> sec_bcd == 8'h00);

  assert_leap_newyear_R3: assert property (@(posedge clk) disable iff (!por_n)
    ($past(field_sel) == 5'd0 && !$stable(leap_phase)) |->
      (month_bcd == 8'h01 && date_bcd == 8'h01));
endmodule

bind calendar_setter calendar_setter_sva u_sva (
  .clk(clk), .por_n(por_n), .clock_mode(clock_mode),
  .sec_bcd(sec_bcd), .min_bcd(min_bcd), .date_bcd(date_bcd),
  .month_bcd(month_bcd), .leap_phase(leap_phase),
  .field_sel(field_sel), .blink(blink)
);

// File: tb/calendar_setter_test.sv
module calendar_setter_test;
  localparam int MSPS = 16, DEB = 2, HOLD = 40, REP = 4, IDLE = 1000;

  logic clk = 1'b0;
  logic por_n = 1'b0, ctl_rst_n = 1'b1, ms_tick = 1'b1, sec_tick = 1'b0;
  logic clock_mode = 1'b1, hour12 = 1'b0, btn_mode = 1'b0, btn_set = 1'b0;
  logic [7:0] sec_bcd, min_bcd, hour_bcd, date_bcd, month_bcd;
  logic [1:0] leap_phase;
  logic [4:0] field_sel, blink;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_mon = 1, m_day = 1, m_hr = 0, m_mn = 0, m_sc = 0, m_lp = 0, m_sel = 0;
  bit m_dirty = 0;

  always #2 clk = ~clk;

  calendar_setter #(.MS_PER_SEC(MSPS), .DEBOUNCE_MS(DEB), .HOLD_MS(HOLD),
                    .REPEAT_MS(REP), .IDLE_MS(IDLE)) uut (
    .clk(clk), .por_n(por_n), .ctl_rst_n(ctl_rst_n), .ms_tick(ms_tick),
    .sec_tick(sec_tick), .clock_mode(clock_mode), .hour12(hour12),
    .btn_mode(btn_mode), .btn_set(btn_set), .sec_bcd(sec_bcd),
    .min_bcd(min_bcd), .hour_bcd(hour_bcd), .date_bcd(date_bcd),
    .month_bcd(month_bcd), .leap_phase(leap_phase), .field_sel(field_sel),
    .blink(blink));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int lp);
    if (mo == 2) return (lp == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int hshow(input int h);
    if (!hour12) return h;
    if (h == 0) return 12;
    return (h > 12) ? h - 12 : h;
  endfunction

  task automatic check_all(input string req);
    chk(req, sec_bcd, bcd(m_sc));
    chk(req, min_bcd, bcd(m_mn));
    chk(req, hour_bcd, bcd(hshow(m_hr)));
    chk(req, date_bcd, bcd(m_day));
    chk(req, month_bcd, bcd(m_mon));
    chk(req, leap_phase, m_lp);
    chk(req, field_sel, (m_sel == 0) ? 0 : (1 << (m_sel - 1)));
  endtask

  task automatic model_inc();
    case (m_sel)
      1: m_mon = (m_mon == 12) ? 1 : m_mon + 1;
      2: m_day = (m_day >= mdays(m_mon, m_lp)) ? 1 : m_day + 1;
      3: m_hr  = (m_hr == 23) ? 0 : m_hr + 1;
      4: m_mn  = (m_mn == 59) ? 0 : m_mn + 1;
      5: m_lp  = (m_lp + 1) % 4;
      default: ;
    endcase
    m_sc = 0;
    m_dirty = 1;
  endtask

  task automatic tick_sec();
    sec_tick = 1'b1; cyc(1); sec_tick = 1'b0; cyc(1);
    if (!(m_sel != 0 && m_dirty)) begin
      m_sc++;
      if (m_sc == 60) begin
        m_sc = 0; m_mn++;
        if (m_mn == 60) begin
          m_mn = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0;
            if (m_day >= mdays(m_mon, m_lp)) begin
              m_day = 1;
              if (m_mon == 12) begin m_mon = 1; m_lp = (m_lp + 1) % 4; end
              else m_mon++;
            end else m_day++;
          end
        end
      end
    end
  endtask

  task automatic press(input bit is_set, input int hold);
    if (is_set) btn_set = 1'b1; else btn_mode = 1'b1;
    cyc(hold);
    btn_set = 1'b0; btn_mode = 1'b0;
    cyc(DEB + 1);
    if (hold >= DEB) begin
      if (!is_set && clock_mode) begin
        m_sel = (m_sel == 5) ? 0 : m_sel + 1;
        if (m_sel == 0) m_dirty = 0;
      end else if (is_set && m_sel != 0) model_inc();
    end
  endtask

  task automatic set_until(input int target);
    int guard = 0;
    while (guard < 70) begin
      case (m_sel)
        1: if (m_mon == target) break;
        2: if (m_day == target) break;
        3: if (m_hr == target) break;
        4: if (m_mn == target) break;
        default: if (m_lp == target) break;
      endcase
      press(1, DEB);
      guard++;
    end
  endtask

  task automatic set_date(input int mo, input int dy, input int hr, input int mn, input int lp);
    press(0, DEB); set_until(mo);
    press(0, DEB); set_until(dy);
    press(0, DEB); set_until(hr);
    press(0, DEB); set_until(mn);
    press(0, DEB); set_until(lp);
    press(0, DEB);
  endtask

  initial begin
    cyc(3);
    por_n = 1'b1;
    cyc(2);
    check_all("R1");
    chk("R1", blink, 0);

    for (int i = 0; i < 130; i++) begin tick_sec(); check_all("R2"); end

    hour12 = 1'b1; cyc(1); check_all("R4"); hour12 = 1'b0;

    press(0, DEB); check_all("R5");
    for (int i = 0; i < 12; i++) begin press(1, DEB); check_all("R6"); end
    for (int i = 0; i < 3; i++) begin tick_sec(); check_all("R7"); end
    set_until(2);
    press(0, DEB); check_all("R5");
    for (int i = 0; i < 29; i++) begin press(1, DEB); check_all("R6"); end
    press(0, DEB); check_all("R5");
    hour12 = 1'b1;
    for (int i = 0; i < 24; i++) begin press(1, DEB); check_all("R4"); end
    hour12 = 1'b0;
    press(0, DEB); check_all("R5");
    for (int i = 0; i < 60; i++) begin press(1, DEB); check_all("R6"); end
    press(0, DEB); check_all("R5");
    for (int i = 0; i < 4; i++) begin press(1, DEB); check_all("R6"); end
    press(0, DEB); check_all("R5");
    for (int i = 0; i < 2; i++) begin tick_sec(); check_all("R7"); end

    btn_mode = 1'b1; cyc(DEB - 1); btn_mode = 1'b0; cyc(DEB + 2);
    check_all("R10");

    press(0, DEB); check_all("R10");
    btn_set = 1'b1; cyc(1 + HOLD + 3 * REP + 2); btn_set = 1'b0; cyc(DEB + 1);
    for (int i = 0; i < 4; i++) model_inc();
    check_all("R8");
    btn_set = 1'b1; cyc(HOLD - 5); btn_set = 1'b0; cyc(DEB + 1);
    model_inc();
    check_all("R8");

    clock_mode = 1'b0; cyc(2); m_sel = 0; m_dirty = 0;
    check_all("R5");
    press(0, DEB); check_all("R5");
    clock_mode = 1'b1; cyc(1);

    press(0, DEB);
    for (int i = 0; i < 2; i++) begin tick_sec(); check_all("R7"); end
    cyc(IDLE - 30); check_all("R9");
    cyc(40); m_sel = 0; m_dirty = 0; check_all("R9");

    press(0, DEB); press(1, DEB);
    ctl_rst_n = 1'b0; cyc(2); ctl_rst_n = 1'b1; cyc(1);
    m_sel = 0; m_dirty = 0;
    check_all("R12");
    tick_sec(); check_all("R12");

    set_date(12, 31, 23, 59, 3);
    check_all("R3");
    for (int i = 0; i < 60; i++) begin tick_sec(); check_all("R3"); end
    set_date(2, 28, 23, 59, 1);
    for (int i = 0; i < 60; i++) begin tick_sec(); check_all("R2"); end

    chk("R11", blink, 0);
    press(0, DEB);
    begin
      int on = 0;
      for (int i = 0; i < MSPS; i++) begin
        cyc(1);
        if (blink == field_sel && blink != 0) on++;
        else chk("R11", blink, 0);
      end
      chk("R11", on, MSPS / 2);
    end
    clock_mode = 1'b0; cyc(2); clock_mode = 1'b1; m_sel = 0; m_dirty = 0;
    check_all("R5");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule